// File: doc/BRIEF.md
# Serial DAC Word Receiver

This block is the digital front end of a 14-bit voltage-output converter. A host writes one conversion code per frame over a three-wire serial link made of an active-low select, a serial clock and a data line. Each frame holds sixteen bits, sent most significant bit first. The first fourteen bits are the code and the last two are sub-bits that must be zero. The received code passes through two storage stages: a holding register that takes a complete frame when select is released, and a DAC latch that feeds the converter.

A load strobe, active low, controls the second stage. While the strobe is low the DAC latch follows the holding register. While it is high the latch keeps its value. Tying the strobe low gives three-wire operation, where the output changes shortly after each good frame. Driving it from the host gives four-wire operation: the host keeps it high during the transfer and pulses it low afterwards, so several converters can change together. A frame of the wrong length is discarded and reported on a one-cycle error pulse. An asynchronous active-low reset returns every register to zero, so the output code is 0.

All serial pins are sampled in the `clk` domain and acted on by edge detection. Each level of the serial clock must therefore be held for at least one `clk` period.

Top module: `sdac_rx`

## Requirements
- R1: While `rst_n` is low, and from the moment it falls, `dac_code` is 0 and `frame_err` is 0, with no clock edge needed.
- R2: While `cs_n` is low, each rising edge of `sclk` shifts in one bit from `din`, MSB first. A 16-bit frame b15..b0 yields code b15..b2, so `dac_code[13]` is the first bit sent.
- R3: When `cs_n` rises after exactly 16 `sclk` rising edges, the code goes to the holding register. With `ldac_n` low, `dac_code` shows the new code by the third `clk` rising edge after the rise of `cs_n` is first sampled.
- R4: When `cs_n` rises after fewer than 16 `sclk` rising edges, `frame_err` pulses and `dac_code` keeps its previous value.
- R5: When `cs_n` rises after more than 16 `sclk` rising edges, `frame_err` pulses and `dac_code` keeps its previous value.
- R6: In a 16-bit frame whose last two bits are not both 0, `frame_err` pulses and the 14-bit code is still accepted.
- R7: While `ldac_n` is high, `dac_code` does not change. Two `clk` rising edges after `ldac_n` is sampled low, `dac_code` equals the holding register.
- R8: Rising edges of `sclk` while `cs_n` is high have no effect, and every falling edge of `cs_n` restarts the bit count at zero.
- R9: `frame_err` is high for exactly one `clk` cycle per frame end, two `clk` rising edges after the rise of `cs_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial bit clock; data is taken on its rising edge |
| din | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load strobe; DAC latch is transparent while low |
| dac_code | output | 14 | Code held in the DAC latch |
| frame_err | output | 1 | One-cycle pulse for a bad frame (wrong length or nonzero sub-bits) |

## Verification
Each output has a fixed latency in `clk` cycles. The frame-error pulse follows the second rising edge after `cs_n` rises and clears at the third. The latched code appears after the third edge in three-wire use, and after the second edge once `ldac_n` falls. The bench drives every input on the falling edge of `clk`. It counts exactly those rising edges and samples on the falling edge that follows, so each check looks at the cycle in which the result is first due. The bench also checks the cycle after each error pulse, to confirm the pulse lasts one cycle. The no-effect cases (stray serial clocks, wrong-length frames, strobe held high) are checked on `dac_code` and `frame_err` after the full latency has passed.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int CODE_W = 14;
  localparam int SUB_W  = 2;
endpackage

// File: rtl/sdac_pin_sampler.sv
module sdac_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  input  logic ldac_n,
  output logic cs_low,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_rise,
  output logic din_s,
  output logic ldac_low
);
  logic cs_q, cs_d, sck_q, sck_d, din_q, ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      cs_d  <= 1'b1;
      sck_q <= 1'b0;
      sck_d <= 1'b0;
      din_q <= 1'b0;
      ld_q  <= 1'b1;
    end else begin
      cs_q  <= cs_n;
      cs_d  <= cs_q;
      sck_q <= sclk;
      sck_d <= sck_q;
      din_q <= din;
      ld_q  <= ldac_n;
    end
  end

  assign cs_low    = ~cs_q;
  assign cs_fall   = ~cs_q & cs_d;
  assign cs_rise   = cs_q & ~cs_d;
  assign sclk_rise = sck_q & ~sck_d;
  assign din_s     = din_q;
  assign ldac_low  = ~ld_q;

  // R9: a select rise is a single-cycle event
  a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !cs_rise);
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int CODE_W = sdac_pkg::CODE_W,
  parameter int SUB_W  = sdac_pkg::SUB_W,
  localparam int FRAME_W = CODE_W + SUB_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_low,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              din_s,
  output logic              frame_ok,
  output logic [CODE_W-1:0] frame_code,
  output logic              frame_err
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               sub_bad;
  logic               err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (cs_fall) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (sclk_rise && cs_low) begin
      shreg <= {shreg[FRAME_W-2:0], din_s};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  assign sub_bad    = |shreg[SUB_W-1:0];
  assign frame_ok   = cs_rise && (cnt == CNT_FULL);
  assign frame_code = shreg[FRAME_W-1:SUB_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= cs_rise && ((cnt != CNT_FULL) || sub_bad);
  end

  assign frame_err = err_q;

  // R8: clocks seen with select high do not move the counter
  a_r8_idle_clock_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !cs_low && !cs_fall) |=> $stable(cnt));
  // R8: every select fall restarts the count
  a_r8_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (cnt == '0));
  // R9: error pulse never lasts two cycles
  a_r9_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch #(
  parameter int CODE_W = sdac_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  logic [CODE_W-1:0] frame_code,
  input  logic              ldac_low,
  output logic [CODE_W-1:0] dac_code
);
  logic [CODE_W-1:0] hold_q;
  logic [CODE_W-1:0] dac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (frame_ok) hold_q <= frame_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dac_q <= '0;
    else if (ldac_low) dac_q <= hold_q;
  end

  assign dac_code = dac_q;

  // R4 R5: holding register moves only on a full-length frame
  a_r4_hold_needs_good_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(hold_q));
  // R7: strobe high freezes the DAC latch
  a_r7_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ldac_low |=> $stable(dac_q));
  // R7: strobe low makes the latch follow the holding register
  a_r7_latch_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ldac_low |=> (dac_q == $past(hold_q)));
endmodule

// File: rtl/sdac_rx.sv
module sdac_rx #(
  parameter int CODE_W = sdac_pkg::CODE_W,
  parameter int SUB_W  = sdac_pkg::SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              ldac_n,
  output logic [CODE_W-1:0] dac_code,
  output logic              frame_err
);
  logic cs_low, cs_fall, cs_rise, sclk_rise, din_s, ldac_low;
  logic frame_ok;
  logic [CODE_W-1:0] frame_code;

  sdac_pin_sampler u_pins (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .ldac_n(ldac_n),
    .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .din_s(din_s), .ldac_low(ldac_low)
  );

  sdac_shifter #(.CODE_W(CODE_W), .SUB_W(SUB_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .din_s(din_s),
    .frame_ok(frame_ok), .frame_code(frame_code), .frame_err(frame_err)
  );

  sdac_latch #(.CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_code(frame_code),
    .ldac_low(ldac_low), .dac_code(dac_code)
  );

  // R1: reset leaves a zero code
  a_r1_reset_zero: assert property (@(posedge clk) $rose(rst_n) |-> (dac_code == '0));
endmodule

// File: tb/sdac_rx_tb.sv
module sdac_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, ldac_n = 1'b0;
  logic [13:0] dac_code;
  logic frame_err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdac_rx u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .ldac_n(ldac_n), .dac_code(dac_code), .frame_err(frame_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse(input logic b);
    @(negedge clk); sclk = 1'b0; din = b;
    wait_n(2); sclk = 1'b1;
    wait_n(2); sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    @(negedge clk); cs_n = 1'b0;
    wait_n(2);
    for (int i = n - 1; i >= 0; i--) sclk_pulse(bits[i]);
    wait_n(1); cs_n = 1'b1;
  endtask

  // after cs_n rises: error due after 2 posedges, DAC after 3
  task automatic frame_end(input string req, input int exp_err, input int exp_dac);
    repeat (2) @(posedge clk);
    @(negedge clk); chk({req, " frame_err pulse"}, frame_err, exp_err);
    @(posedge clk);
    @(negedge clk); chk("R9 frame_err cleared", frame_err, 0);
    chk({req, " dac_code"}, dac_code, exp_dac);
  endtask

  task automatic t_reset;
    chk("R1 dac_code at reset", dac_code, 0);
    chk("R1 frame_err at reset", frame_err, 0);
    wait_n(2); rst_n = 1'b1; wait_n(2);
    chk("R1 dac_code after release", dac_code, 0);
  endtask

  task automatic t_three_wire;
    send_bits({14'h2A5C, 2'b00}, 16);  frame_end("R3", 0, 14'h2A5C);
    send_bits({14'h3FFF, 2'b00}, 16);  frame_end("R2", 0, 14'h3FFF);
    send_bits({14'h0001, 2'b00}, 16);  frame_end("R2", 0, 14'h0001);
  endtask

  task automatic t_short;
    send_bits({14'h1234, 2'b00} >> 1, 15); frame_end("R4", 1, 14'h0001);
  endtask

  task automatic t_long;
    send_bits({1'b1, 14'h1111, 2'b00}, 17); frame_end("R5", 1, 14'h0001);
  endtask

  task automatic t_subbits;
    send_bits({14'h0BEE, 2'b10}, 16); frame_end("R6", 1, 14'h0BEE);
  endtask

  task automatic t_idle_clocks;
    for (int i = 0; i < 5; i++) sclk_pulse(1'b1);
    wait_n(3);
    chk("R8 idle clocks dac", dac_code, 14'h0BEE);
    chk("R8 idle clocks err", frame_err, 0);
    // aborted partial frame then a full frame: count restarts
    send_bits(32'h7, 3); frame_end("R8 partial", 1, 14'h0BEE);
    send_bits({14'h0777, 2'b00}, 16); frame_end("R8 restart", 0, 14'h0777);
  endtask

  task automatic t_four_wire;
    @(negedge clk); ldac_n = 1'b1;
    send_bits({14'h1C3A, 2'b00}, 16); frame_end("R7 held", 0, 14'h0777);
    wait_n(4);
    chk("R7 still held", dac_code, 14'h0777);
    @(negedge clk); ldac_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); chk("R7 load", dac_code, 14'h1C3A);
  endtask

  task automatic t_async_reset;
    #1 rst_n = 1'b0;
    #0.5 chk("R1 async clear", dac_code, 0);
    wait_n(2); rst_n = 1'b1; wait_n(1);
  endtask

  initial begin
    t_reset();
    t_three_wire();
    t_short();
    t_long();
    t_subbits();
    t_idle_clocks();
    t_four_wire();
    t_async_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule